// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block sits between a register port and the serial engine of an SPI controller. It holds a transmit queue and a receive queue of 32 words of 16 bits each, reports their fill levels and flags, raises interrupts from level thresholds and from latched error events, and asks a DMA engine for service when a queue crosses its watermark. Software talks to it through a single-cycle register port: a write takes effect at the clock edge, and read data is presented combinationally for the address on the port. Reading the receive data address with the read strobe high pops one word at that edge.

The serial engine sees two valid/ready streams. On the transmit side the unit offers words (`tx_valid`) and the engine takes one on every edge where `tx_ready` is also high. On the receive side the engine offers words (`rx_valid`) and the unit accepts on edges where `rx_ready` is high. A serial engine cannot stall the wire, so back-pressure on the receive side is not a wait: a word offered while `rx_ready` is low is lost, and if the unit is enabled the loss is latched as a receive overflow. While the unit is disabled both queues are held empty, `tx_valid` and `rx_ready` stay low, and data accesses from either side are ignored without raising any flag.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: Register addresses on `reg_addr`: 0 control (bit 0 enable), 1 status, 2 transmit threshold, 3 receive threshold, 4 transmit level, 5 receive level, 6 interrupt mask, 7 masked interrupts, 8 raw interrupts, 9 clear, 10 DMA control, 11 transmit DMA watermark, 12 receive DMA watermark, 13 transmit data (write pushes), 14 receive data (read pops). The status word has busy (copy of `engine_busy`) in bit 0, transmit full in bit 1, transmit empty in bit 2, receive empty in bit 3 and receive full in bit 4; after reset it reads 0x0C.
- R2: Each queue is first-in first-out with 32 entries; its level (0 to 32) reads back at its level address, and words leave in the order they entered.
- R3: A register write to transmit data while the transmit queue is full is dropped and sets raw bit 1; a register read of receive data while the receive queue is empty returns zero and sets raw bit 2.
- R4: A word offered on `rx_valid` while enabled and the receive queue is full is dropped and sets raw bit 3.
- R5: While enabled, raw bit 0 is high when the transmit level is at or below the transmit threshold; raw bit 4 is high when the receive level is strictly above the receive threshold.
- R6: The two thresholds and the two DMA watermarks are 5 bits wide; a written value reads back modulo 32.
- R7: The masked register equals raw AND mask (same bit layout), and `irq` is high exactly when any masked bit is high.
- R8: A clear write with bit 0 set clears all three latched bits; bit 1 clears raw bit 2, bit 2 clears raw bit 3, bit 3 clears raw bit 1; a latch event in the same cycle as its clear wins.
- R9: DMA control bit 0 enables `rx_dma_req`, raised while the receive level exceeds the receive watermark; bit 1 enables `tx_dma_req`, raised while the transmit level is at or below the transmit watermark; both are low while disabled.
- R10: Writing the enable bit to 0 empties both queues at that edge; while disabled, data writes, data reads (which return zero) and offered receive words change no level and set no flag.
- R11: `tx_valid` is high exactly when enabled and the transmit queue is not empty, with `tx_data` the oldest word; `rx_ready` is high exactly when enabled and the receive queue is not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on receive data address) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational |
| engine_busy | input | 1 | Serial engine busy, reported in status |
| tx_valid | output | 1 | Transmit word available to the engine |
| tx_ready | input | 1 | Engine takes the transmit word |
| tx_data | output | 16 | Oldest transmit word |
| rx_valid | input | 1 | Engine offers a received word |
| rx_ready | output | 1 | Receive queue can accept |
| rx_data | input | 16 | Received word |
| irq | output | 1 | OR of masked interrupt bits |
| tx_dma_req | output | 1 | Transmit DMA service request |
| rx_dma_req | output | 1 | Receive DMA service request |

## Verification
Every cycle, the assertions check that levels stay within the queue depth, that a push into a full transmit queue or a pop of an empty receive queue latches its flag without growing the level, that a receive word refused while enabled latches overflow, that disabling leaves both queues empty, that a zero mask keeps `irq` low and that a receive DMA request never appears on an empty queue. Word ordering, the exact threshold and watermark crossing points at every fill level, the modulo-32 readback, the per-bit clear coding and the full mask sweep can only be shown by the bench's sweeps, which fill and drain both queues through all 33 levels.

// File: rtl/spi_fifo_irq_pkg.sv
package spi_fifo_irq_pkg;

  localparam int unsigned QDEPTH = 32;
  localparam int unsigned QWIDTH = 16;

  typedef enum logic [3:0] {
    RA_CTRL    = 4'd0,
    RA_STATUS  = 4'd1,
    RA_TX_THR  = 4'd2,
    RA_RX_THR  = 4'd3,
    RA_TX_LVL  = 4'd4,
    RA_RX_LVL  = 4'd5,
    RA_MASK    = 4'd6,
    RA_MASKED  = 4'd7,
    RA_RAW     = 4'd8,
    RA_CLEAR   = 4'd9,
    RA_DMA     = 4'd10,
    RA_TX_WM   = 4'd11,
    RA_RX_WM   = 4'd12,
    RA_TX_DATA = 4'd13,
    RA_RX_DATA = 4'd14
  } reg_addr_e;

  // interrupt bit positions (shared by raw, mask and masked words)
  localparam int unsigned IB_TX_LOW  = 0;
  localparam int unsigned IB_TX_OVF  = 1;
  localparam int unsigned IB_RX_UNF  = 2;
  localparam int unsigned IB_RX_OVF  = 3;
  localparam int unsigned IB_RX_HIGH = 4;
  localparam int unsigned IRQ_BITS   = 5;

  // clear word bit positions
  localparam int unsigned CB_ALL    = 0;
  localparam int unsigned CB_RX_UNF = 1;
  localparam int unsigned CB_RX_OVF = 2;
  localparam int unsigned CB_TX_OVF = 3;

endpackage

// File: rtl/sfi_sync_fifo.sv
module sfi_sync_fifo #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == LW'(DEPTH));
  assign empty   = (cnt == '0);
  assign level   = cnt;
  assign rdata   = mem[rd_ptr];
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/sfi_irq_ctrl.sv
module sfi_irq_ctrl
  import spi_fifo_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tx_low,
  input  logic                rx_high,
  input  logic                ev_tx_ovf,
  input  logic                ev_rx_unf,
  input  logic                ev_rx_ovf,
  input  logic                clr_we,
  input  logic [3:0]          clr,
  input  logic [IRQ_BITS-1:0] mask,
  output logic [IRQ_BITS-1:0] raw,
  output logic [IRQ_BITS-1:0] masked,
  output logic                irq
);

  logic tx_ovf_q, rx_unf_q, rx_ovf_q;
  logic clr_all;

  assign clr_all = clr_we && clr[CB_ALL];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_ovf_q <= 1'b0;
      rx_unf_q <= 1'b0;
      rx_ovf_q <= 1'b0;
    end else begin
      // a new event outranks a clear issued in the same cycle
      tx_ovf_q <= ev_tx_ovf || (tx_ovf_q && !(clr_all || (clr_we && clr[CB_TX_OVF])));
      rx_unf_q <= ev_rx_unf || (rx_unf_q && !(clr_all || (clr_we && clr[CB_RX_UNF])));
      rx_ovf_q <= ev_rx_ovf || (rx_ovf_q && !(clr_all || (clr_we && clr[CB_RX_OVF])));
    end
  end

  always_comb begin
    raw             = '0;
    raw[IB_TX_LOW]  = tx_low;
    raw[IB_TX_OVF]  = tx_ovf_q;
    raw[IB_RX_UNF]  = rx_unf_q;
    raw[IB_RX_OVF]  = rx_ovf_q;
    raw[IB_RX_HIGH] = rx_high;
  end

  for (genvar b = 0; b < IRQ_BITS; b++) begin : g_mask
    assign masked[b] = raw[b] && mask[b];
  end

  assign irq = |masked;

endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit
  import spi_fifo_irq_pkg::*;
#(
  parameter int unsigned DEPTH = QDEPTH,
  parameter int unsigned DW    = QWIDTH,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [3:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          engine_busy,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [DW-1:0] tx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [DW-1:0] rx_data,
  output logic          irq,
  output logic          tx_dma_req,
  output logic          rx_dma_req
);

  logic                en_q;
  logic [AW-1:0]       tx_thr_q, rx_thr_q, tx_wm_q, rx_wm_q;
  logic [IRQ_BITS-1:0] mask_q;
  logic [1:0]          dma_q;

  logic [LW-1:0]       tx_lvl, rx_lvl;
  logic                tx_full, tx_empty, rx_full, rx_empty;
  logic [DW-1:0]       rx_head;
  logic [IRQ_BITS-1:0] raw, masked;
  logic                flush, cpu_push, cpu_pop;
  logic [4:0]          status;

  function automatic logic wr_at(input reg_addr_e a);
    return reg_wr && (reg_addr == a);
  endfunction

  assign cpu_push = wr_at(RA_TX_DATA);
  assign cpu_pop  = reg_rd && (reg_addr == RA_RX_DATA);
  // a write clearing the enable empties both queues at that same edge
  assign flush    = wr_at(RA_CTRL) ? !reg_wdata[0] : !en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      tx_thr_q <= '0;
      rx_thr_q <= '0;
      tx_wm_q  <= '0;
      rx_wm_q  <= '0;
      mask_q   <= '0;
      dma_q    <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        RA_CTRL:   en_q     <= reg_wdata[0];
        RA_TX_THR: tx_thr_q <= reg_wdata[AW-1:0];
        RA_RX_THR: rx_thr_q <= reg_wdata[AW-1:0];
        RA_TX_WM:  tx_wm_q  <= reg_wdata[AW-1:0];
        RA_RX_WM:  rx_wm_q  <= reg_wdata[AW-1:0];
        RA_MASK:   mask_q   <= reg_wdata[IRQ_BITS-1:0];
        RA_DMA:    dma_q    <= reg_wdata[1:0];
        default:   ;
      endcase
    end
  end

  sfi_sync_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (cpu_push && en_q),
    .wdata (reg_wdata),
    .pop   (tx_ready && tx_valid),
    .rdata (tx_data),
    .level (tx_lvl),
    .full  (tx_full),
    .empty (tx_empty)
  );

  sfi_sync_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (rx_valid && rx_ready),
    .wdata (rx_data),
    .pop   (cpu_pop && en_q),
    .rdata (rx_head),
    .level (rx_lvl),
    .full  (rx_full),
    .empty (rx_empty)
  );

  assign tx_valid = en_q && !tx_empty;
  assign rx_ready = en_q && !rx_full;

  sfi_irq_ctrl u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_low    (en_q && (tx_lvl <= LW'(tx_thr_q))),
    .rx_high   (en_q && (rx_lvl > LW'(rx_thr_q))),
    .ev_tx_ovf (cpu_push && en_q && tx_full),
    .ev_rx_unf (cpu_pop && en_q && rx_empty),
    .ev_rx_ovf (rx_valid && en_q && rx_full),
    .clr_we    (wr_at(RA_CLEAR)),
    .clr       (reg_wdata[3:0]),
    .mask      (mask_q),
    .raw       (raw),
    .masked    (masked),
    .irq       (irq)
  );

  assign tx_dma_req = en_q && dma_q[1] && (tx_lvl <= LW'(tx_wm_q));
  assign rx_dma_req = en_q && dma_q[0] && (rx_lvl > LW'(rx_wm_q));

  assign status = {rx_full, rx_empty, tx_empty, tx_full, engine_busy};

  always_comb begin
    case (reg_addr)
      RA_CTRL:    reg_rdata = DW'(en_q);
      RA_STATUS:  reg_rdata = DW'(status);
      RA_TX_THR:  reg_rdata = DW'(tx_thr_q);
      RA_RX_THR:  reg_rdata = DW'(rx_thr_q);
      RA_TX_LVL:  reg_rdata = DW'(tx_lvl);
      RA_RX_LVL:  reg_rdata = DW'(rx_lvl);
      RA_MASK:    reg_rdata = DW'(mask_q);
      RA_MASKED:  reg_rdata = DW'(masked);
      RA_RAW:     reg_rdata = DW'(raw);
      RA_DMA:     reg_rdata = DW'(dma_q);
      RA_TX_WM:   reg_rdata = DW'(tx_wm_q);
      RA_RX_WM:   reg_rdata = DW'(rx_wm_q);
      RA_RX_DATA: reg_rdata = (en_q && !rx_empty) ? rx_head : '0;
      default:    reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/spi_fifo_irq_unit_chk.sv
module spi_fifo_irq_unit_chk
  import spi_fifo_irq_pkg::*;
#(
  parameter int unsigned DEPTH = QDEPTH,
  parameter int unsigned LW    = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                en,
  input logic                reg_wr,
  input logic                reg_rd,
  input logic [3:0]          reg_addr,
  input logic                rx_valid,
  input logic                rx_ready,
  input logic [LW-1:0]       tx_lvl,
  input logic [LW-1:0]       rx_lvl,
  input logic [IRQ_BITS-1:0] raw,
  input logic [IRQ_BITS-1:0] mask,
  input logic                irq,
  input logic                rx_dma_req
);

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_lvl <= LW'(DEPTH)) && (rx_lvl <= LW'(DEPTH))); // R2

  AST_TX_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && reg_wr && reg_addr == RA_TX_DATA && tx_lvl == LW'(DEPTH))
    |=> (raw[IB_TX_OVF] && tx_lvl <= $past(tx_lvl))); // R3

  AST_RX_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && reg_rd && reg_addr == RA_RX_DATA && rx_lvl == '0)
    |=> (raw[IB_RX_UNF] && rx_lvl <= $past(rx_lvl) + 1'b1)); // R3

  AST_RX_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rx_valid && !rx_ready) |=> raw[IB_RX_OVF]); // R4

  AST_NO_MASK_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq); // R7

  AST_RXDMA_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dma_req |-> (rx_lvl != '0)); // R9

  AST_DISABLE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |-> (tx_lvl == '0 && rx_lvl == '0)); // R10

  AST_READY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !rx_ready); // R11

endmodule

bind spi_fifo_irq_unit spi_fifo_irq_unit_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en_q),
  .reg_wr     (reg_wr),
  .reg_rd     (reg_rd),
  .reg_addr   (reg_addr),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .tx_lvl     (tx_lvl),
  .rx_lvl     (rx_lvl),
  .raw        (raw),
  .mask       (mask_q),
  .irq        (irq),
  .rx_dma_req (rx_dma_req)
);

// File: tb/spi_fifo_irq_unit_bench.sv
module spi_fifo_irq_unit_bench;

  localparam int A_CTRL = 0, A_STATUS = 1, A_TX_THR = 2, A_RX_THR = 3;
  localparam int A_TX_LVL = 4, A_RX_LVL = 5, A_MASK = 6, A_MASKED = 7;
  localparam int A_RAW = 8, A_CLEAR = 9, A_DMA = 10, A_TX_WM = 11;
  localparam int A_RX_WM = 12, A_TX_DATA = 13, A_RX_DATA = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        engine_busy = 1'b0;
  logic        tx_valid, tx_ready = 1'b0;
  logic [15:0] tx_data;
  logic        rx_valid = 1'b0, rx_ready;
  logic [15:0] rx_data = '0;
  logic        irq, tx_dma_req, rx_dma_req;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  spi_fifo_irq_unit u_spi_fifo_irq_unit (
    .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
    .engine_busy, .tx_valid, .tx_ready, .tx_data, .rx_valid, .rx_ready,
    .rx_data, .irq, .tx_dma_req, .rx_dma_req
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 4'(a);
    #1 d = int'(reg_rdata);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic eng_push(input int d);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 16'(d);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic eng_pop(output int v, output int d);
    @(negedge clk);
    tx_ready = 1'b1;
    #1 v = int'(tx_valid); d = int'(tx_data);
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
    end
  end

  function automatic int txw(input int k);
    return (16'hA000 + k * 37) & 16'hFFFF;
  endfunction

  function automatic int rxw(input int k);
    return (k * 16'h0111 + 3) & 16'hFFFF;
  endfunction

  initial begin
    int d, v, r;
    int regs [4];
    regs = '{A_TX_THR, A_RX_THR, A_TX_WM, A_RX_WM};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R7 irq after reset", int'(irq), 0);
    chk("R9 dma after reset", int'({tx_dma_req, rx_dma_req}), 0);
    chk("R11 handshake after reset", int'({tx_valid, rx_ready}), 0);
    rd(A_STATUS, d); chk("R1 status after reset", d, 'h0C);

    // disabled: data accesses ignored
    wr(A_TX_DATA, 'h1234);
    rd(A_TX_LVL, d); chk("R10 disabled push level", d, 0);
    rd(A_RX_DATA, d); chk("R10 disabled pop data", d, 0);
    rd(A_RAW, d);     chk("R10 disabled raw", d, 0);

    wr(A_CTRL, 1);
    rd(A_RAW, d); chk("R5 tx low at level 0", d & 1, 1);
    chk("R11 ready when enabled", int'(rx_ready), 1);

    // modulo-32 readback sweep
    foreach (regs[i]) begin
      for (int val = 0; val < 48; val += 5) begin
        wr(regs[i], val);
        rd(regs[i], d); chk("R6 threshold readback", d, val % 32);
      end
    end

    // transmit fill sweep
    wr(A_TX_THR, 10); wr(A_TX_WM, 20); wr(A_DMA, 3); wr(A_MASK, 0);
    for (int k = 1; k <= 32; k++) begin
      wr(A_TX_DATA, txw(k));
      rd(A_TX_LVL, d); chk("R2 tx level", d, k);
      rd(A_RAW, d);    chk("R5 tx low bit", d & 1, (k <= 10) ? 1 : 0);
      chk("R9 tx dma", int'(tx_dma_req), (k <= 20) ? 1 : 0);
      rd(A_STATUS, d); chk("R1 tx full/empty", (d >> 1) & 3, (k == 32) ? 1 : 0);
    end
    wr(A_TX_DATA, 'hFFFF);
    rd(A_TX_LVL, d); chk("R3 tx overflow level", d, 32);
    rd(A_RAW, d);    chk("R3 tx overflow bit", (d >> 1) & 1, 1);
    for (int k = 1; k <= 32; k++) begin
      eng_pop(v, d);
      chk("R11 tx valid", v, 1);
      chk("R2 tx order", d, txw(k));
    end
    @(negedge clk);
    chk("R11 tx valid empty", int'(tx_valid), 0);
    rd(A_STATUS, d); chk("R1 tx empty bit", (d >> 2) & 1, 1);

    // receive fill sweep
    wr(A_RX_THR, 7); wr(A_RX_WM, 12);
    for (int k = 1; k <= 32; k++) begin
      eng_push(rxw(k));
      rd(A_RX_LVL, d); chk("R2 rx level", d, k);
      rd(A_RAW, d);    chk("R5 rx high bit", (d >> 4) & 1, (k > 7) ? 1 : 0);
      chk("R9 rx dma", int'(rx_dma_req), (k > 12) ? 1 : 0);
      chk("R11 rx ready", int'(rx_ready), (k < 32) ? 1 : 0);
    end
    eng_push('hBEEF);
    rd(A_RX_LVL, d); chk("R4 rx overflow level", d, 32);
    rd(A_RAW, d);    chk("R4 rx overflow bit", (d >> 3) & 1, 1);
    rd(A_STATUS, d); chk("R1 rx full bit", (d >> 3) & 3, 2);
    for (int k = 1; k <= 32; k++) begin
      rd(A_RX_DATA, d); chk("R2 rx order", d, rxw(k));
    end
    rd(A_RX_DATA, d); chk("R3 rx empty read data", d, 0);
    rd(A_RAW, d);     chk("R3 rx underflow raw", d, 'h0F);

    // mask sweep with raw = 0x0F
    for (int m = 0; m < 32; m++) begin
      wr(A_MASK, m);
      rd(A_MASKED, d); chk("R7 masked", d, 'h0F & m);
      chk("R7 irq", int'(irq), (('h0F & m) != 0) ? 1 : 0);
    end

    // selective clears
    wr(A_CLEAR, 2); rd(A_RAW, d); chk("R8 clear rx underflow", d, 'h0B);
    wr(A_CLEAR, 4); rd(A_RAW, d); chk("R8 clear rx overflow", d, 'h03);
    wr(A_CLEAR, 8); rd(A_RAW, d); chk("R8 clear tx overflow", d, 'h01);
    rd(A_RX_DATA, r);
    rd(A_RAW, d);   chk("R3 underflow again", d, 'h05);
    wr(A_CLEAR, 1); rd(A_RAW, d); chk("R8 clear all", d, 'h01);

    // busy bit
    engine_busy = 1'b1;
    rd(A_STATUS, d); chk("R1 busy bit", d, 'h0D);
    engine_busy = 1'b0;

    // flush on disable
    wr(A_TX_DATA, 1); wr(A_TX_DATA, 2); wr(A_TX_DATA, 3);
    eng_push(5); eng_push(6);
    rd(A_TX_LVL, d); chk("R2 tx level before flush", d, 3);
    wr(A_CTRL, 0);
    rd(A_TX_LVL, d); chk("R10 tx flushed", d, 0);
    rd(A_RX_LVL, d); chk("R10 rx flushed", d, 0);
    rd(A_STATUS, d); chk("R10 status flushed", d, 'h0C);
    chk("R9 dma off when disabled", int'({tx_dma_req, rx_dma_req}), 0);
    eng_push(7);
    rd(A_RX_LVL, d); chk("R11 rx refused when disabled", d, 0);
    rd(A_RAW, d);    chk("R10 no flag when disabled", d, 0);

    finished = 1;
    summary();
  end

endmodule